// File: doc/BRIEF.md
# Dual-Mode Alarm Indication Signal Detector

This block watches a received 2.048 Mb/s bit stream for the all-ones alarm indication signal. It counts zeros over fixed observation spans and raises an alarm status when the stream carries almost no zeros. There are two detection criteria, and a mode input picks one of them. The frame criterion works on consecutive 512-bit double-frame periods. It needs two quiet periods in a row to raise the alarm and two noisy periods in a row to drop it. A frame-alignment-found pulse also drops the alarm at once. The window criterion works on one long observation window, 250 ms by default. It raises the alarm when the window is quiet and the framer reports lost alignment at the close of the window. Otherwise it drops the alarm at that close.

A rising edge of the alarm status produces a one-cycle interrupt pulse. A simulation input forces the status high so that the path to software can be tested. When the simulation input is released, the status returns to whatever the real detector holds. Framing itself is handled elsewhere. This block only consumes the alignment flags.

Top module: `ais_detector`

## Requirements
- R1: With `mode_sel`=1 (frame mode), two consecutive 512-bit periods that each hold at most two zeros (a zero is `bit_in`=0 on a valid cycle) set `ais`. `ais` goes high two clock cycles after the last valid bit of the second period. A quiet period that follows a noisy period, or a restart, does not set it.
- R2: In frame mode, two consecutive periods that each hold three or more zeros clear `ais`. A single period whose verdict differs from the one before it leaves `ais` unchanged.
- R3: In frame mode, a `fas_found` pulse clears the alarm condition. `ais` is low on the cycle after the pulse, unless `sim_en` is high. This clear takes priority over a set in the same cycle.
- R4: With `mode_sel`=0 (window mode), a window of `WINDOW_BITS` valid bits with at most two zeros sets `ais`, but only if `lfa` is high on the window's last valid bit. With `lfa` low, a quiet window does not set it.
- R5: In window mode, every window that closes without meeting the R4 condition clears `ais`.
- R6: `ais_irq` is high for exactly one cycle: the first cycle in which `ais` is high after being low.
- R7: `ais` is high on the cycle after any cycle with `sim_en` high. After `sim_en` falls, `ais` follows the real alarm condition, which is unchanged by the simulation.
- R8: A change of `mode_sel` restarts all period and window counters and the period history. The bit presented on the cycle of the change is discarded. The change does not alter `ais`.
- R9: Cycles with `bit_vld` low are not counted, whatever `bit_in` carries.
- R10: During and just after a synchronous reset, `ais` and `ais_irq` are low and all counts are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Marks a cycle carrying a received bit |
| bit_in | input | 1 | Received data bit |
| mode_sel | input | 1 | 1 selects frame mode, 0 selects window mode |
| lfa | input | 1 | Framer reports loss of frame alignment |
| fas_found | input | 1 | One-cycle pulse: frame alignment signal found |
| sim_en | input | 1 | Alarm simulation: forces the status high |
| ais | output | 1 | Registered alarm status |
| ais_irq | output | 1 | One-cycle pulse on the rising edge of `ais` |

## Verification
The case that is hardest to reach is the two-period history in frame mode, combined with a mode change that must wipe that history but leave the status alone. The stimulus first sends one quiet period. It then toggles `mode_sel` twice with no bits in between and sends a single further quiet period. The alarm must stay low, although without the restart it would have been set. Zero counts exactly at the boundary (two and three zeros) are also driven, as are periods interleaved with invalid cycles that carry zeros. A behavioural model in the bench tracks the expected status and pulse on every cycle.

// File: rtl/ais_pkg.sv
package ais_pkg;
  typedef enum logic {
    MODE_WINDOW = 1'b0,
    MODE_FRAME  = 1'b1
  } ais_mode_e;

  // Verdict of one closed observation span.
  typedef struct packed {
    logic done;   // one-cycle pulse after the span's last valid bit
    logic quiet;  // span held at most QUIET_MAX zeros (and was qualified)
  } verdict_t;

  localparam int unsigned QUIET_MAX = 2;
endpackage

// File: rtl/ais_zero_tally.sv
module ais_zero_tally
  import ais_pkg::*;
#(
  parameter int unsigned LEN = 512
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     clr,
  input  logic     bit_vld,
  input  logic     bit_in,
  input  logic     qual,
  output verdict_t vd
);
  localparam int unsigned CW = (LEN > 2) ? $clog2(LEN) : 1;

  logic [CW-1:0] pos;
  logic [1:0]    zc;
  logic [1:0]    zsum;
  logic          last;

  assign last = (pos == CW'(LEN - 1));

  // Saturating zero count including the current bit.
  always_comb begin
    if (bit_in || zc == 2'd3) zsum = zc;
    else                      zsum = zc + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos <= '0;
      zc  <= '0;
      vd  <= '0;
    end else begin
      vd.done <= 1'b0;
      if (en && bit_vld) begin
        if (last) begin
          pos      <= '0;
          zc       <= '0;
          vd.done  <= 1'b1;
          vd.quiet <= (zsum <= 2'(QUIET_MAX)) && qual;
        end else begin
          pos <= pos + CW'(1);
          zc  <= zsum;
        end
      end
    end
  end
endmodule

// File: rtl/ais_pair_judge.sv
module ais_pair_judge
  import ais_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  verdict_t vd,
  output logic     set_req,
  output logic     clr_req
);
  logic hist;
  logic hist_ok;

  assign set_req = vd.done && hist_ok &&  hist &&  vd.quiet;
  assign clr_req = vd.done && hist_ok && !hist && !vd.quiet;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist    <= 1'b0;
      hist_ok <= 1'b0;
    end else if (vd.done) begin
      hist    <= vd.quiet;
      hist_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/ais_alarm_core.sv
module ais_alarm_core
  import ais_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      restart,
  input  ais_mode_e mode,
  input  logic      fas_found,
  input  logic      sim_en,
  input  logic      f_set,
  input  logic      f_clr,
  input  verdict_t  w_vd,
  output logic      ais,
  output logic      ais_irq
);
  logic cond;
  logic cond_d;
  logic ais_d;

  always_comb begin
    cond_d = cond;
    if (!restart) begin
      if (mode == MODE_FRAME) begin
        if (fas_found)  cond_d = 1'b0;
        else if (f_set) cond_d = 1'b1;
        else if (f_clr) cond_d = 1'b0;
      end else if (w_vd.done) begin
        cond_d = w_vd.quiet;
      end
    end
    ais_d = cond_d | sim_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond    <= 1'b0;
      ais     <= 1'b0;
      ais_irq <= 1'b0;
    end else begin
      cond    <= cond_d;
      ais     <= ais_d;
      ais_irq <= ais_d & ~ais;
    end
  end
endmodule

// File: rtl/ais_detector.sv
module ais_detector
  import ais_pkg::*;
#(
  parameter int unsigned PERIOD_BITS = 512,
  parameter int unsigned WINDOW_BITS = 512000
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic mode_sel,
  input  logic lfa,
  input  logic fas_found,
  input  logic sim_en,
  output logic ais,
  output logic ais_irq
);
  ais_mode_e mode;
  logic      mode_q;
  logic      restart;
  verdict_t  f_vd;
  verdict_t  w_vd;
  logic      f_set;
  logic      f_clr;
  logic      eval_pulse;

  assign mode       = ais_mode_e'(mode_sel);
  assign restart    = (mode_sel != mode_q);
  assign eval_pulse = f_vd.done | w_vd.done;

  always_ff @(posedge clk) begin
    mode_q <= mode_sel;
  end

  ais_zero_tally #(.LEN(PERIOD_BITS)) u_frame_tally (
    .clk     (clk),
    .rst     (rst),
    .en      (mode == MODE_FRAME),
    .clr     (restart),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .qual    (1'b1),
    .vd      (f_vd)
  );

  ais_zero_tally #(.LEN(WINDOW_BITS)) u_window_tally (
    .clk     (clk),
    .rst     (rst),
    .en      (mode == MODE_WINDOW),
    .clr     (restart),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .qual    (lfa),
    .vd      (w_vd)
  );

  ais_pair_judge u_judge (
    .clk     (clk),
    .rst     (rst),
    .clr     (restart),
    .vd      (f_vd),
    .set_req (f_set),
    .clr_req (f_clr)
  );

  ais_alarm_core u_core (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .mode      (mode),
    .fas_found (fas_found),
    .sim_en    (sim_en),
    .f_set     (f_set),
    .f_clr     (f_clr),
    .w_vd      (w_vd),
    .ais       (ais),
    .ais_irq   (ais_irq)
  );
endmodule

// File: rtl/ais_detector_sva.sv
module ais_detector_sva (
  input logic clk,
  input logic rst,
  input logic mode_sel,
  input logic fas_found,
  input logic sim_en,
  input logic ais,
  input logic ais_irq,
  input logic restart,
  input logic eval_pulse
);
  // R1, R4: the status only rises after a span verdict or under simulation
  a_r1_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ais) |-> ($past(eval_pulse) || $past(sim_en)));

  a_r3_fas_clears: assert property (@(posedge clk) disable iff (rst)
    (fas_found && mode_sel && !restart && !sim_en) |=> !ais);

  a_r6_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
    ais_irq |-> (ais && !$past(ais)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ais_irq |=> !ais_irq);

  a_r7_sim_forces: assert property (@(posedge clk) disable iff (rst)
    sim_en |=> ais);

  a_r8_restart_keeps: assert property (@(posedge clk) disable iff (rst)
    (restart && (sim_en == $past(sim_en))) |=> $stable(ais));
endmodule

bind ais_detector ais_detector_sva u_sva (
  .clk        (clk),
  .rst        (rst),
  .mode_sel   (mode_sel),
  .fas_found  (fas_found),
  .sim_en     (sim_en),
  .ais        (ais),
  .ais_irq    (ais_irq),
  .restart    (restart),
  .eval_pulse (eval_pulse)
);

// File: tb/tb_ais_detector.sv
`timescale 1ns/1ps
module tb_ais_detector;
  localparam int P = 512;
  localparam int W = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0, bit_in = 1'b1, mode_sel = 1'b1;
  logic lfa = 1'b0, fas_found = 1'b0, sim_en = 1'b0;
  logic ais, ais_irq;

  int checks = 0;
  int errors = 0;
  string phase = "R10";

  always #4 clk = ~clk;

  ais_detector #(.PERIOD_BITS(P), .WINDOW_BITS(W)) dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .mode_sel(mode_sel), .lfa(lfa), .fas_found(fas_found),
    .sim_en(sim_en), .ais(ais), .ais_irq(ais_irq)
  );

  // Behavioural reference model
  int m_prev_mode, m_fpos, m_fz, m_wpos, m_wz;
  bit m_fdone, m_fquiet, m_wdone, m_wquiet, m_hok, m_hist;
  bit m_cond, exp_ais, exp_irq;

  always @(posedge clk) begin
    if (rst) begin
      m_prev_mode = mode_sel; m_fpos = 0; m_fz = 0; m_wpos = 0; m_wz = 0;
      m_fdone = 0; m_fquiet = 0; m_wdone = 0; m_wquiet = 0;
      m_hok = 0; m_hist = 0; m_cond = 0; exp_ais = 0; exp_irq = 0;
    end else begin
      bit rs, ncond, nais, nfdone, nwdone;
      int tot;
      rs = (mode_sel != m_prev_mode);
      m_prev_mode = mode_sel;
      ncond = m_cond;
      if (!rs) begin
        if (mode_sel) begin
          if (fas_found) ncond = 0;
          else if (m_fdone && m_hok && m_hist && m_fquiet) ncond = 1;
          else if (m_fdone && m_hok && !m_hist && !m_fquiet) ncond = 0;
        end else if (m_wdone) ncond = m_wquiet;
      end
      nais = ncond | sim_en;
      exp_irq = nais && !exp_ais;
      exp_ais = nais;
      m_cond = ncond;
      if (rs) begin m_hok = 0; m_hist = 0; end
      else if (m_fdone) begin m_hist = m_fquiet; m_hok = 1; end
      nfdone = 0; nwdone = 0;
      if (rs) begin
        m_fpos = 0; m_fz = 0; m_wpos = 0; m_wz = 0;
      end else if (bit_vld) begin
        if (mode_sel) begin
          tot = m_fz + (bit_in ? 0 : 1); if (tot > 3) tot = 3;
          if (m_fpos == P - 1) begin
            nfdone = 1; m_fquiet = (tot <= 2); m_fpos = 0; m_fz = 0;
          end else begin m_fpos++; m_fz = tot; end
        end else begin
          tot = m_wz + (bit_in ? 0 : 1); if (tot > 3) tot = 3;
          if (m_wpos == W - 1) begin
            nwdone = 1; m_wquiet = (tot <= 2) && lfa; m_wpos = 0; m_wz = 0;
          end else begin m_wpos++; m_wz = tot; end
        end
      end
      m_fdone = nfdone; m_wdone = nwdone;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(ais === exp_ais, {phase, " model ais"}, ais, exp_ais);
      chk(ais_irq === exp_irq, {phase, " model irq"}, ais_irq, exp_irq);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_vld = 0; fas_found = 0;
    end
  endtask

  // One span of len valid bits, the first nz of them zero.
  task automatic span(input int len, input int nz, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps) begin @(negedge clk); bit_vld = 0; bit_in = 0; end
      @(negedge clk); bit_vld = 1; bit_in = (i < nz) ? 1'b0 : 1'b1;
    end
    @(negedge clk); bit_vld = 0; bit_in = 1;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ais == 0, "R10 reset ais", ais, 0);
    chk(ais_irq == 0, "R10 reset irq", ais_irq, 0);
    rst = 0;
    idle(2);
    chk(ais == 0, "R10 after reset", ais, 0);

    phase = "R1";
    span(P, 0, 0);
    chk(ais == 0, "R1 one quiet period", ais, 0);
    span(P, 0, 0);
    @(negedge clk);
    chk(ais == 1, "R1 set after two quiet", ais, 1);
    chk(ais_irq == 1, "R6 irq on rise", ais_irq, 1);
    @(negedge clk);
    chk(ais_irq == 0, "R6 irq single cycle", ais_irq, 0);

    phase = "R2";
    span(P, 3, 0); idle(1);
    chk(ais == 1, "R2 one noisy period keeps", ais, 1);
    span(P, 3, 0); idle(1);
    chk(ais == 0, "R2 cleared by two noisy", ais, 0);
    span(P, 2, 0); span(P, 2, 0); idle(1);
    chk(ais == 1, "R1 boundary two zeros", ais, 1);

    phase = "R3";
    @(negedge clk); fas_found = 1;
    @(negedge clk); fas_found = 0;
    chk(ais == 0, "R3 fas clears", ais, 0);

    phase = "R9";
    span(P, 3, 0); span(P, 0, 1); span(P, 0, 1); idle(1);
    chk(ais == 1, "R9 invalid zeros ignored", ais, 1);
    span(P, 3, 0); span(P, 3, 0); idle(1);

    phase = "R8";
    span(P, 0, 0);
    @(negedge clk); mode_sel = 0;
    @(negedge clk); mode_sel = 1;
    span(P, 0, 0); idle(1);
    chk(ais == 0, "R8 history wiped", ais, 0);
    span(P, 0, 0); idle(1);
    chk(ais == 1, "R8 set after fresh pair", ais, 1);
    @(negedge clk); mode_sel = 0; bit_vld = 1; bit_in = 0;
    @(negedge clk); bit_vld = 0; bit_in = 1;
    chk(ais == 1, "R8 switch keeps status", ais, 1);

    phase = "R5";
    lfa = 0;
    span(W, 0, 0); idle(1);
    chk(ais == 0, "R5 cleared when lfa low", ais, 0);
    phase = "R4";
    lfa = 1;
    span(W, 2, 0); idle(1);
    chk(ais == 1, "R4 set quiet window lfa", ais, 1);
    phase = "R5";
    span(W, 3, 0); idle(1);
    chk(ais == 0, "R5 cleared by noisy window", ais, 0);

    phase = "R7";
    @(negedge clk); sim_en = 1;
    @(negedge clk);
    chk(ais == 1, "R7 sim forces", ais, 1);
    chk(ais_irq == 1, "R7 sim rise irq", ais_irq, 1);
    idle(3); sim_en = 0;
    @(negedge clk);
    chk(ais == 0, "R7 release to clear", ais, 0);
    span(W, 0, 0); idle(1);
    @(negedge clk); sim_en = 1; idle(2); sim_en = 0; idle(2);
    chk(ais == 1, "R7 release keeps real alarm", ais, 1);
    idle(4);
    report();
  end
endmodule